// File: doc/BRIEF.md
# Filtered Pulse Capture and Generation Timer Pair

This block measures and produces pulse trains with two counter/timers, one 8 bits wide and one 16 bits wide, fed by a shared input path. The measured signal is taken from either a comparator-side pin or a general-purpose pin. It is brought into the clock domain and sampled on a divided clock tick. A glitch filter then removes short pulses, and an edge detector decides which transitions count as events. In capture mode each timer counts divided ticks between selected events. The 8-bit timer stores the length of a high level and the length of a low level in separate registers. The 16-bit timer keeps only the most recent length. In generate mode a timer builds a square wave with separate high and low lengths taken from reload values.

Three pins can be driven by the block: the 8-bit wave, the 16-bit wave, and a mix of the two through an AND or an OR gate. When its enable bit is clear, a pin carries the matching bit of a default value supplied by the surrounding port logic. Software reaches the block through a synchronous 16-bit register port. Writes are taken on the clock edge and reads decode combinationally. Two sticky interrupt flags report captures and terminal counts.

The counter reloads when an event arrives. For a clean square input with the filter threshold at zero, this makes each capture equal the level's length in ticks. Input pulses are assumed to last at least three clock cycles and to repeat no faster than eight.

Top module: `pulse_timer_pair`

## Requirements
- R1: After reset all control and capture state is zero. `irq_t8` and `irq_t16` are low, and `out_t8`, `out_t16` and `out_mix` follow `port_dflt[0]`, `port_dflt[1]` and `port_dflt[2]`.
- R2: The glitch filter changes its level only after the synchronised input has differed from that level on threshold+1 consecutive ticks. The threshold is taken from config register 0, bits 8:5. A shorter pulse causes no event.
- R3: In config register 0, bits 1:0 select the edges (00 none, 01 rising, 10 falling, 11 both). With both edges selected, a falling event loads 8-bit capture bits 7:0 with the high length in ticks. A rising event loads bits 15:8 with the low length. Both are read at address 4.
- R4: An 8-bit capture of a level longer than 255 ticks reads 255, because the counter saturates and does not wrap.
- R5: With rising edges only, the 8-bit low capture receives the full period and the high capture is left unchanged. With edge mode 00, no capture and no interrupt takes place.
- R6: Config register 0 bit 2 selects the source: 0 selects `pin_cmp` and 1 selects `pin_gpio`. Activity on the pin that is not selected has no effect.
- R7: A capture or a terminal count sets the timer's flag, bit 0 for 8-bit and bit 1 for 16-bit, readable at address 7. Writing a 1 to that bit at address 7 clears the flag.
- R8: Control registers sit at address 1 (8-bit) and address 2 (16-bit), with bit 0 run, bit 1 generate and bit 2 pin drive. In generate mode the wave starts low for lo+1 ticks and then alternates with hi+1 ticks high. The reloads are at address 4 (hi in bits 7:0, lo in bits 15:8) and at addresses 5 and 6 for the 16-bit timer.
- R9: Config register 0 bits 4:3 hold k, and a tick occurs once every 2^k clock cycles.
- R10: Address 3 bit 0 selects OR (1) or AND (0) of the two waves, and bit 1 enables `out_mix`. A pin whose drive bit is clear shows its `port_dflt` bit.
- R11: The 16-bit timer has a single capture, read at address 5, which holds the length of the level that ended most recently, up to 65535 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| pin_cmp | input | 1 | Measured input, comparator-side pin |
| pin_gpio | input | 1 | Measured input, general I/O pin |
| port_dflt | input | 3 | Fallback pin values when drive is off |
| out_t8 | output | 1 | 8-bit timer pin |
| out_t16 | output | 1 | 16-bit timer pin |
| out_mix | output | 1 | AND/OR mix pin |
| irq_t8 | output | 1 | 8-bit timer interrupt flag |
| irq_t16 | output | 1 | 16-bit timer interrupt flag |

## Verification
The hardest condition to reach from the ports is a pulse that the glitch filter just barely rejects next to one it just barely accepts. The filter runs two synchroniser stages after the pin and needs its count to match the threshold exactly. The stimulus sets a threshold of two and drives pulses of two and three clock cycles with the divider at one, which separates the two cases by a single sample. Counter saturation is reached by holding a level for more than 255 ticks. The expected width of a generated wave is checked by counting high cycles over a window that is a whole number of periods, so the result does not depend on the phase.

// File: rtl/ptp_pkg.sv
package ptp_pkg;
    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
    localparam logic [REG_AW-1:0] RA_T8CTL = 3'd1;
    localparam logic [REG_AW-1:0] RA_T16CTL = 3'd2;
    localparam logic [REG_AW-1:0] RA_MIX   = 3'd3;
    localparam logic [REG_AW-1:0] RA_T8RL  = 3'd4;
    localparam logic [REG_AW-1:0] RA_T16HI = 3'd5;
    localparam logic [REG_AW-1:0] RA_T16LO = 3'd6;
    localparam logic [REG_AW-1:0] RA_IRQ   = 3'd7;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/ptp_front.sv
module ptp_front #(
    parameter int FILT_W = 4,
    parameter int DSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_a,
    input  logic              pin_b,
    input  logic              src_sel,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic [FILT_W-1:0] filt_thr,
    input  logic [1:0]        edge_mode,
    output logic              tick,
    output logic              evt,
    output logic              evt_fall
);
    import ptp_pkg::*;

    localparam int DCNT_W = (1 << DSEL_W) - 1;

    typedef struct packed {
        logic [1:0]        sync;
        logic [DCNT_W-1:0] div;
        logic [FILT_W-1:0] fcnt;
        logic              level;
        logic              level_dly;
    } front_t;

    front_t s_d, s_q;
    logic [DCNT_W-1:0] mask;
    logic rise, fall;

    always_comb begin
        mask = DCNT_W'((1 << div_sel) - 1);
        tick = ((s_q.div & mask) == mask);
        s_d  = s_q;
        s_d.sync      = {s_q.sync[0], src_sel ? pin_b : pin_a};
        s_d.div       = s_q.div + 1'b1;
        s_d.level_dly = s_q.level;
        if (s_q.sync[1] == s_q.level) begin
            s_d.fcnt = '0;
        end else if (tick) begin
            if (s_q.fcnt >= filt_thr) begin
                s_d.level = s_q.sync[1];
                s_d.fcnt  = '0;
            end else begin
                s_d.fcnt = s_q.fcnt + 1'b1;
            end
        end
        rise     = s_q.level & ~s_q.level_dly;
        fall     = ~s_q.level & s_q.level_dly;
        evt      = (rise && (edge_mode == EDGE_RISE || edge_mode == EDGE_BOTH)) ||
                   (fall && (edge_mode == EDGE_FALL || edge_mode == EDGE_BOTH));
        evt_fall = fall;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ptp_timer.sv
module ptp_timer #(
    parameter int CNT_W = 8,
    parameter int NCAP  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  evt,
    input  logic                  evt_fall,
    input  logic                  run,
    input  logic                  gen,
    input  logic [CNT_W-1:0]      rl_hi,
    input  logic [CNT_W-1:0]      rl_lo,
    output logic [NCAP*CNT_W-1:0] cap,
    output logic                  wave,
    output logic                  done
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [NCAP-1:0][CNT_W-1:0]  cap;
        logic                        wave;
    } tmr_t;

    tmr_t s_d, s_q;
    int   slot;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        slot = (NCAP > 1 && !evt_fall) ? 1 : 0;
        if (!run) begin
            s_d.cnt  = rl_lo;
            s_d.wave = 1'b0;
        end else if (gen) begin
            if (tick) begin
                if (s_q.cnt == '0) begin
                    s_d.wave = ~s_q.wave;
                    s_d.cnt  = s_q.wave ? rl_lo : rl_hi;
                    done     = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
        end else if (evt) begin
            for (int i = 0; i < NCAP; i++) begin
                if (i == slot) s_d.cap[i] = s_q.cnt;
            end
            s_d.cnt = tick ? CNT_W'(1) : '0;
            done    = 1'b1;
        end else if (tick && s_q.cnt != CNT_MAX) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cap  = s_q.cap;
    assign wave = s_q.wave;
endmodule

// File: rtl/pulse_timer_pair.sv
module pulse_timer_pair #(
    parameter int NARROW_W = 8,
    parameter int WIDE_W   = 16,
    parameter int FILT_W   = 4,
    parameter int DSEL_W   = 2,
    parameter int DATA_W   = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ptp_pkg::REG_AW-1:0]  addr,
    input  logic [DATA_W-1:0]           wdata,
    output logic [DATA_W-1:0]           rdata,
    input  logic                        pin_cmp,
    input  logic                        pin_gpio,
    input  logic [2:0]                  port_dflt,
    output logic                        out_t8,
    output logic                        out_t16,
    output logic                        out_mix,
    output logic                        irq_t8,
    output logic                        irq_t16
);
    import ptp_pkg::*;

    localparam int DIV_LSB  = 3;
    localparam int FILT_LSB = DIV_LSB + DSEL_W;

    typedef struct packed {
        logic [1:0]          edge_mode;
        logic                src;
        logic [DSEL_W-1:0]   div_sel;
        logic [FILT_W-1:0]   filt;
        logic                t8_run, t8_gen, t8_oe;
        logic                t16_run, t16_gen, t16_oe;
        logic                mix_or, mix_oe;
        logic [NARROW_W-1:0] t8_hi, t8_lo;
        logic [WIDE_W-1:0]   t16_hi, t16_lo;
        logic                irq8, irq16;
    } regs_t;

    regs_t r_d, r_q;

    logic tick, evt, evt_fall;
    logic t8_run, t8_gen, t8_wave, t8_done;
    logic t16_wave, t16_done;
    logic [2*NARROW_W-1:0] t8_cap;
    logic [WIDE_W-1:0]     t16_cap;
    logic clr8, clr16, mix;

    assign t8_run = r_q.t8_run;
    assign t8_gen = r_q.t8_gen;

    ptp_front #(.FILT_W(FILT_W), .DSEL_W(DSEL_W)) u_front (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_cmp), .pin_b(pin_gpio),
        .src_sel(r_q.src), .div_sel(r_q.div_sel), .filt_thr(r_q.filt),
        .edge_mode(r_q.edge_mode), .tick(tick), .evt(evt), .evt_fall(evt_fall)
    );

    ptp_timer #(.CNT_W(NARROW_W), .NCAP(2)) u_t8 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .evt_fall(evt_fall),
        .run(t8_run), .gen(t8_gen), .rl_hi(r_q.t8_hi), .rl_lo(r_q.t8_lo),
        .cap(t8_cap), .wave(t8_wave), .done(t8_done)
    );

    ptp_timer #(.CNT_W(WIDE_W), .NCAP(1)) u_t16 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .evt_fall(evt_fall),
        .run(r_q.t16_run), .gen(r_q.t16_gen), .rl_hi(r_q.t16_hi), .rl_lo(r_q.t16_lo),
        .cap(t16_cap), .wave(t16_wave), .done(t16_done)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (addr)
                RA_CFG: begin
                    r_d.edge_mode = wdata[1:0];
                    r_d.src       = wdata[2];
                    r_d.div_sel   = wdata[DIV_LSB +: DSEL_W];
                    r_d.filt      = wdata[FILT_LSB +: FILT_W];
                end
                RA_T8CTL:  {r_d.t8_oe, r_d.t8_gen, r_d.t8_run}    = wdata[2:0];
                RA_T16CTL: {r_d.t16_oe, r_d.t16_gen, r_d.t16_run} = wdata[2:0];
                RA_MIX:    {r_d.mix_oe, r_d.mix_or}               = wdata[1:0];
                RA_T8RL: begin
                    r_d.t8_hi = wdata[NARROW_W-1:0];
                    r_d.t8_lo = wdata[2*NARROW_W-1:NARROW_W];
                end
                RA_T16HI: r_d.t16_hi = wdata[WIDE_W-1:0];
                RA_T16LO: r_d.t16_lo = wdata[WIDE_W-1:0];
                default: ;
            endcase
        end
        clr8      = wr_en && (addr == RA_IRQ) && wdata[0];
        clr16     = wr_en && (addr == RA_IRQ) && wdata[1];
        r_d.irq8  = (r_q.irq8 & ~clr8) | t8_done;
        r_d.irq16 = (r_q.irq16 & ~clr16) | t16_done;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (addr)
            RA_CFG:    rdata = DATA_W'({r_q.filt, r_q.div_sel, r_q.src, r_q.edge_mode});
            RA_T8CTL:  rdata = DATA_W'({r_q.t8_oe, r_q.t8_gen, r_q.t8_run});
            RA_T16CTL: rdata = DATA_W'({r_q.t16_oe, r_q.t16_gen, r_q.t16_run});
            RA_MIX:    rdata = DATA_W'({r_q.mix_oe, r_q.mix_or});
            RA_T8RL:   rdata = DATA_W'(t8_cap);
            RA_T16HI:  rdata = DATA_W'(t16_cap);
            RA_T16LO:  rdata = DATA_W'(r_q.t16_lo);
            default:   rdata = DATA_W'({r_q.irq16, r_q.irq8});
        endcase
        mix     = r_q.mix_or ? (t8_wave | t16_wave) : (t8_wave & t16_wave);
        out_t8  = r_q.t8_oe  ? t8_wave  : port_dflt[0];
        out_t16 = r_q.t16_oe ? t16_wave : port_dflt[1];
        out_mix = r_q.mix_oe ? mix      : port_dflt[2];
    end

    assign irq_t8  = r_q.irq8;
    assign irq_t16 = r_q.irq16;
endmodule

// File: rtl/ptp_chk.sv
module ptp_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          evt,
    input logic          run8,
    input logic          gen8,
    input logic [CW-1:0] cap8,
    input logic          irq8,
    input logic          wave8
);
    // R2: a filtered edge can only follow a divided sample tick
    a_r2_evt_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(tick));

    // R3: captures move only on a selected edge
    a_r3_caps_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(cap8));

    // R7: a capture raises the interrupt flag
    a_r7_irq_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && run8 && !gen8) |=> irq8);

    // R8: the generated wave changes only on a tick
    a_r8_wave_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (run8 && gen8 && !tick) |=> $stable(wave8));
endmodule

bind pulse_timer_pair ptp_chk #(.CW(2*NARROW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt), .run8(t8_run),
    .gen8(t8_gen), .cap8(t8_cap), .irq8(irq_t8), .wave8(t8_wave)
);

// File: tb/sim_pulse_timer_pair.sv
module sim_pulse_timer_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        pin_cmp = 1'b0, pin_gpio = 1'b0;
    logic [2:0]  port_dflt = 3'b101;
    logic        out_t8, out_t16, out_mix, irq_t8, irq_t16;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pulse_timer_pair u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_cmp(pin_cmp), .pin_gpio(pin_gpio), .port_dflt(port_dflt),
        .out_t8(out_t8), .out_t16(out_t16), .out_mix(out_mix),
        .irq_t8(irq_t8), .irq_t16(irq_t16)
    );

    // {high, low, expected high capture, expected low capture, expected wide capture}
    localparam int NV = 5;
    localparam int VEC [NV][5] = '{
        '{5, 7, 5, 7, 7},
        '{3, 3, 3, 3, 3},
        '{12, 40, 12, 40, 40},
        '{300, 9, 255, 9, 9},
        '{9, 300, 9, 255, 300}
    };

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pin_cmp = 1'b0; pin_gpio = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_cmp(input int h, input int l);
        pin_cmp = 1'b1; wait_n(h);
        pin_cmp = 1'b0; wait_n(l);
    endtask

    task automatic count_high(input int sel, input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if ((sel == 0 && out_t8) || (sel == 1 && out_t16) || (sel == 2 && out_mix)) c++;
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog got=%0d exp=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] d;
        int c;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 out_t8", out_t8, 1);
        chk("R1 out_t16", out_t16, 0);
        chk("R1 out_mix", out_mix, 1);
        chk("R1 irq_t8", irq_t8, 0);
        chk("R1 irq_t16", irq_t16, 0);
        rd(3'd4, d); chk("R1 t8 caps", d, 0);
        rd(3'd5, d); chk("R1 t16 cap", d, 0);

        // R3 R4 R11 vector table, both edges, divide by one
        wr(3'd0, 16'h0003);
        wr(3'd1, 16'h0001);
        wr(3'd2, 16'h0001);
        for (int i = 0; i < NV; i++) begin
            pin_cmp = 1'b0; wait_n(20);
            pulse_cmp(VEC[i][0], VEC[i][1]);
            pin_cmp = 1'b1; wait_n(10);
            rd(3'd4, d);
            chk("R3 R4 high capture", d[7:0], VEC[i][2]);
            chk("R3 R4 low capture", d[15:8], VEC[i][3]);
            rd(3'd5, d);
            chk("R11 wide capture", d, VEC[i][4]);
        end
        // R7 flag set then cleared
        chk("R7 irq_t8 set", irq_t8, 1);
        wr(3'd7, 16'h0001);
        chk("R7 irq_t8 cleared", irq_t8, 0);

        // R5 rising edges only, then edges off
        do_reset();
        wr(3'd0, 16'h0001);
        wr(3'd1, 16'h0001);
        wait_n(10);
        pulse_cmp(6, 10);
        pin_cmp = 1'b1; wait_n(8);
        rd(3'd4, d);
        chk("R5 rise-only period", d[15:8], 16);
        chk("R5 rise-only high untouched", d[7:0], 0);
        wr(3'd0, 16'h0000);
        wr(3'd7, 16'h0001);
        pulse_cmp(5, 5); wait_n(6);
        chk("R5 mode none no irq", irq_t8, 0);
        rd(3'd4, d); chk("R5 mode none caps", d, 16'h1000);

        // R2 glitch filter threshold 2
        do_reset();
        wr(3'd0, 16'h0043);
        wr(3'd1, 16'h0001);
        wait_n(10);
        pulse_cmp(2, 12);
        chk("R2 short pulse rejected", irq_t8, 0);
        pulse_cmp(3, 12);
        chk("R2 long pulse accepted", irq_t8, 1);
        rd(3'd4, d); chk("R2 filtered high length", d[7:0], 3);

        // R6 source select
        do_reset();
        wr(3'd0, 16'h0007);
        wr(3'd1, 16'h0001);
        wait_n(5);
        pulse_cmp(10, 10);
        chk("R6 unselected pin ignored", irq_t8, 0);
        pin_gpio = 1'b1; wait_n(7);
        pin_gpio = 1'b0; wait_n(10);
        rd(3'd4, d); chk("R6 selected pin captured", d[7:0], 7);

        // R8 generate: lo=3 hi=2
        do_reset();
        wr(3'd4, 16'h0302);
        wr(3'd1, 16'h0007);
        wait_n(3);
        chk("R8 low phase", out_t8, 0);
        @(negedge clk);
        chk("R8 first rise", out_t8, 1);
        wait_n(5);
        count_high(0, 70, c); chk("R8 duty over 10 periods", c, 30);

        // R9 divider
        wr(3'd0, 16'h0008);
        wait_n(20);
        count_high(0, 140, c); chk("R9 divide by 2", c, 60);
        wr(3'd0, 16'h0010);
        wait_n(40);
        count_high(0, 280, c); chk("R9 divide by 4", c, 120);
        wr(3'd0, 16'h0000);
        wait_n(10);

        // R10 mix with wide timer stopped
        wr(3'd3, 16'h0002);
        count_high(2, 70, c); chk("R10 AND with idle", c, 0);
        wr(3'd3, 16'h0003);
        count_high(2, 70, c); chk("R10 OR with idle", c, 30);
        wr(3'd3, 16'h0001);
        count_high(2, 14, c); chk("R10 mix fallback", c, 14);
        wr(3'd1, 16'h0003);
        count_high(0, 14, c); chk("R10 t8 fallback", c, 14);

        // R8 wide timer with zero reloads toggles every tick
        wr(3'd5, 16'h0000);
        wr(3'd6, 16'h0000);
        wr(3'd2, 16'h0007);
        wait_n(4);
        count_high(1, 70, c); chk("R8 wide toggle", c, 35);
        chk("R7 irq_t16 on terminal count", irq_t16, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule